// File: doc/BRIEF.md
# Power-Management Tick Generator with Fast-Test Bypass

This block turns a real-time-clock enable pulse into the low-rate, single-cycle enable ticks used by power-management logic. It serves four blink-rate time bases, one debounce time base, four inactivity-timer time bases and one time base for the power-button override count. Each tick comes from its own divider, and a parameter sets each ratio.

An 8-bit test register sits behind a small write/read port. When its lowest bit is set, every tick output stops using its divider and repeats the undivided real-time-clock enable. This shortens long power-management intervals in simulation and on the tester. The upper seven bits are scratch storage only. Only the soft reset clears the register. The system reset, which is active across soft-off, clears the dividers but leaves the register unchanged.

Top module: `pm_slowclk_gen`

## Requirements
- R1: While `soft_rst_n` is low at a clock edge, the test register goes to 0x00. All tick outputs are 0 in the cycle after that edge.
- R2: A write of `cfg_wdata` with `cfg_wr` high is visible on `cfg_rdata` from the next cycle. With no write, the register holds its value. All 8 bits read back.
- R3: Bits 7..1 of the test register have no effect on any tick output.
- R4: With bit 0 = 0, output k pulses high for exactly one cycle, in the cycle after every DIV(k)-th cycle in which `rtc_tick` is high. The count starts from reset or from the last restart. The ratios are: blink k uses BLINK_BASE·2^k, debounce uses DBNC_DIV, inactivity k uses IDLE_BASE·2^k, and override uses PBO_DIV.
- R5: With bit 0 = 1, every tick output equals `rtc_tick` delayed by one cycle.
- R6: A write that changes bit 0 forces all tick outputs to 0 in the following cycle and restarts every divider. After a change back to normal mode, output k's first tick follows the DIV(k)-th `rtc_tick` pulse after the write.
- R7: While `rst_n` is low, dividers clear and tick outputs are 0, but the test register keeps its value.
- R8: A write that leaves bit 0 unchanged does not restart any divider.
- R9: No tick output is high in the cycle after a cycle in which `rtc_tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous system reset, active low; clears dividers only |
| soft_rst_n | input | 1 | Synchronous soft reset, active low; clears register and dividers |
| rtc_tick | input | 1 | Real-time-clock derived enable, one cycle per RTC period |
| cfg_wr | input | 1 | Test register write strobe |
| cfg_wdata | input | 8 | Test register write data |
| cfg_rdata | output | 8 | Test register contents |
| blink_tick | output | 4 | Blink time-base ticks |
| dbnc_tick | output | 1 | Debounce time-base tick |
| idle_tick | output | 4 | Inactivity-timer time-base ticks |
| pbo_tick | output | 1 | Power-button override time-base tick |

## Verification
The assertions assume that `rtc_tick` is a synchronous level sampled at each clock edge. It may be high on consecutive cycles or at any irregular spacing. They also assume that register writes may arrive in any cycle, including cycles with an `rtc_tick` pulse. The stimulus drives every input half a cycle away from the sampling edge. It covers continuous, evenly spaced and pseudo-random `rtc_tick` patterns. Mode writes land on arbitrary divider phases. Both resets are applied only outside the checked windows of the properties, which those resets disable.

// File: rtl/pm_slowclk_pkg.sv
package pm_slowclk_pkg;

  localparam int unsigned NUM_BLINK = 4;
  localparam int unsigned NUM_IDLE  = 4;
  localparam int unsigned NUM_TICKS = NUM_BLINK + 1 + NUM_IDLE + 1;

  // Ratio of a tick in a doubling family: base times 2^k.
  function automatic int unsigned scaled_div(int unsigned base, int unsigned k);
    return base << k;
  endfunction

  // Ratio of tick slot idx in the packed ordering blink, debounce, idle, override.
  function automatic int unsigned slot_div(int unsigned idx, int unsigned blink_base,
                                           int unsigned dbnc, int unsigned idle_base,
                                           int unsigned pbo);
    if (idx < NUM_BLINK) return scaled_div(blink_base, idx);
    if (idx == NUM_BLINK) return dbnc;
    if (idx < NUM_BLINK + 1 + NUM_IDLE) return scaled_div(idle_base, idx - NUM_BLINK - 1);
    return pbo;
  endfunction

endpackage

// File: rtl/pm_tick_div.sv
module pm_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic hit
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign hit = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   cnt <= '0;
    else if (step)       cnt <= hit ? '0 : cnt + 1'b1;
  end

  // R4: the count never passes the last value of its period
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R9: a divider fires only on a reference step
  a_r9_hit_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> step);

  // R6: a restart leaves the count at zero
  a_r6_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/pm_test_reg.sv
module pm_test_reg (
  input  logic       clk,
  input  logic       soft_rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] q,
  output logic       bypass,
  output logic       mode_chg
);
  always_ff @(posedge clk) begin
    if (!soft_rst_n) q <= 8'h00;
    else if (wr_en)  q <= wdata;
  end

  assign bypass   = q[0];
  assign mode_chg = wr_en && (wdata[0] != q[0]);

  // R2: written value appears next cycle
  a_r2_write: assert property (@(posedge clk) disable iff (!soft_rst_n)
    wr_en |=> (q == $past(wdata)));

  // R2 / R7: without a write the register holds, whatever the system reset does
  a_r2_hold: assert property (@(posedge clk) disable iff (!soft_rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/pm_slowclk_gen.sv
module pm_slowclk_gen #(
  parameter int unsigned BLINK_BASE = 4,
  parameter int unsigned DBNC_DIV   = 3,
  parameter int unsigned IDLE_BASE  = 5,
  parameter int unsigned PBO_DIV    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst_n,
  input  logic       rtc_tick,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic [3:0] blink_tick,
  output logic       dbnc_tick,
  output logic [3:0] idle_tick,
  output logic       pbo_tick
);
  import pm_slowclk_pkg::*;

  localparam int unsigned NT = NUM_TICKS;

  logic          bypass;
  logic          mode_chg;
  logic          div_rst_n;
  logic [NT-1:0] div_hit;
  logic [NT-1:0] tick_d;
  logic [NT-1:0] tick_q;

  assign div_rst_n = rst_n && soft_rst_n;

  pm_test_reg u_reg (
    .clk        (clk),
    .soft_rst_n (soft_rst_n),
    .wr_en      (cfg_wr),
    .wdata      (cfg_wdata),
    .q          (cfg_rdata),
    .bypass     (bypass),
    .mode_chg   (mode_chg)
  );

  for (genvar i = 0; i < NT; i++) begin : g_div
    localparam int unsigned D = slot_div(i, BLINK_BASE, DBNC_DIV, IDLE_BASE, PBO_DIV);
    pm_tick_div #(.DIV(D)) u_div (
      .clk   (clk),
      .rst_n (div_rst_n),
      .clr   (mode_chg),
      .step  (rtc_tick),
      .hit   (div_hit[i])
    );
    assign tick_d[i] = !mode_chg && (bypass ? rtc_tick : div_hit[i]);
  end

  always_ff @(posedge clk) begin
    if (!div_rst_n) tick_q <= '0;
    else            tick_q <= tick_d;
  end

  assign blink_tick = tick_q[NUM_BLINK-1:0];
  assign dbnc_tick  = tick_q[NUM_BLINK];
  assign idle_tick  = tick_q[NUM_BLINK+NUM_IDLE:NUM_BLINK+1];
  assign pbo_tick   = tick_q[NT-1];

  // R5: bypass mode mirrors the reference on every output
  a_r5_bypass_follow: assert property (@(posedge clk) disable iff (!div_rst_n)
    (bypass && !mode_chg) |=> (tick_q == {NT{$past(rtc_tick)}}));

  // R6: a mode switch is followed by one quiet cycle
  a_r6_switch_quiet: assert property (@(posedge clk) disable iff (!div_rst_n)
    mode_chg |=> (tick_q == '0));

  // R9: no reference pulse, no tick
  a_r9_no_ref_no_tick: assert property (@(posedge clk) disable iff (!div_rst_n)
    !rtc_tick |=> (tick_q == '0));

  // R7: system reset silences ticks
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (tick_q == '0));
endmodule

// File: tb/pm_slowclk_gen_test.sv
`timescale 1ns/1ps
module pm_slowclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst_n, rtc_tick, cfg_wr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [3:0] blink_tick, idle_tick;
  logic       dbnc_tick, pbo_tick;

  always #2.5 clk = ~clk;

  pm_slowclk_gen uut (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .rtc_tick(rtc_tick),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .blink_tick(blink_tick), .dbnc_tick(dbnc_tick),
    .idle_tick(idle_tick), .pbo_tick(pbo_tick)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int unsigned mcnt [10];
  logic [7:0] mreg;
  logic [9:0] mexp;
  int phase_err, rd_err;
  logic [9:0] first_got, first_exp;
  logic [7:0] lfsr = 8'h5A;

  // Ratios restated: blink 4,8,16,32; debounce 3; idle 5,10,20,40; override 7
  function automatic int unsigned bdiv(int i);
    case (i)
      0: return 4;   1: return 8;   2: return 16;  3: return 32;
      4: return 3;
      5: return 5;   6: return 10;  7: return 20;  8: return 40;
      default: return 7;
    endcase
  endfunction

  function automatic logic [9:0] got_ticks();
    return {pbo_tick, idle_tick, dbnc_tick, blink_tick};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic rtc, logic wr, logic [7:0] wd, logic rn, logic srn);
    logic chg;
    rtc_tick = rtc; cfg_wr = wr; cfg_wdata = wd; rst_n = rn; soft_rst_n = srn;
    chg = wr && (wd[0] != mreg[0]);
    for (int i = 0; i < 10; i++) begin
      if (!rn || !srn) begin
        mexp[i] = 1'b0; mcnt[i] = 0;
      end else begin
        mexp[i] = chg ? 1'b0 : (mreg[0] ? rtc : (rtc && mcnt[i] == bdiv(i) - 1));
        if (chg) mcnt[i] = 0;
        else if (rtc) mcnt[i] = (mcnt[i] == bdiv(i) - 1) ? 0 : mcnt[i] + 1;
      end
    end
    if (!srn) mreg = 8'h00;
    else if (wr) mreg = wd;
    @(posedge clk);
    @(negedge clk);
    if (got_ticks() !== mexp) begin
      if (phase_err == 0) begin first_got = got_ticks(); first_exp = mexp; end
      phase_err++;
    end
    if (cfg_rdata !== mreg) rd_err++;
  endtask

  task automatic start_phase();
    phase_err = 0; rd_err = 0; first_got = '0; first_exp = '0;
  endtask

  task automatic end_phase(string req, string what);
    check(phase_err == 0, req, what, int'(first_got), int'(first_exp));
  endtask

  task automatic run(int n, int mode);
    for (int k = 0; k < n; k++) begin
      logic r;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (mode)
        0: r = 1'b1;
        1: r = (k % 3) == 0;
        default: r = lfsr[0];
      endcase
      cyc(r, 1'b0, 8'h00, 1'b1, 1'b1);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    mreg = 8'hxx;
    for (int i = 0; i < 10; i++) mcnt[i] = 0;
    rtc_tick = 0; cfg_wr = 0; cfg_wdata = 0; rst_n = 0; soft_rst_n = 0;
    @(negedge clk);
    start_phase();
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    // R1: reset state
    check(cfg_rdata == 8'h00, "R1", "register after soft reset", cfg_rdata, 0);
    check(got_ticks() == 10'h0, "R1", "ticks after soft reset", got_ticks(), 0);

    start_phase(); run(200, 0); end_phase("R4", "continuous reference");
    start_phase(); run(300, 1); end_phase("R9", "every third reference pulse");
    start_phase(); run(400, 2); end_phase("R4", "irregular reference");

    // R3 / R8: upper bits and an unchanged bit 0 leave the dividers alone
    start_phase();
    cyc(1'b1, 1'b1, 8'hFE, 1'b1, 1'b1);
    run(300, 2);
    end_phase("R3", "upper test bits ignored");
    check(cfg_rdata == 8'hFE, "R2", "readback of upper bits", cfg_rdata, 8'hFE);
    start_phase();
    cyc(1'b1, 1'b1, 8'h6A, 1'b1, 1'b1);
    run(150, 0);
    end_phase("R8", "same-mode write keeps phase");

    // R5 / R6: into bypass
    start_phase();
    cyc(1'b1, 1'b1, 8'h01, 1'b1, 1'b1);
    check(got_ticks() == 10'h0, "R6", "quiet cycle entering bypass", got_ticks(), 0);
    run(120, 2); run(20, 0);
    end_phase("R5", "bypass follows reference");

    // R6: back to normal restarts every divider
    start_phase();
    run(3, 2);
    cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    check(got_ticks() == 10'h0, "R6", "quiet cycle leaving bypass", got_ticks(), 0);
    run(300, 0); run(200, 2);
    end_phase("R6", "restart after leaving bypass");

    // R7: system reset keeps the register
    start_phase();
    cyc(1'b1, 1'b1, 8'h5B, 1'b1, 1'b1);
    run(7, 2);
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
    check(cfg_rdata == 8'h5B, "R7", "register across system reset", cfg_rdata, 8'h5B);
    check(got_ticks() == 10'h0, "R7", "ticks in system reset", got_ticks(), 0);
    run(60, 2);
    end_phase("R5", "bypass after system reset");

    // R1: soft reset clears register; R4 from a clean start
    start_phase();
    cyc(1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check(cfg_rdata == 8'h00, "R1", "register cleared by soft reset", cfg_rdata, 0);
    run(250, 2);
    end_phase("R4", "normal after soft reset");

    // R2: sweep of all write values
    start_phase();
    for (int v = 0; v < 256; v++) cyc(1'b0, 1'b1, 8'(v), 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    check(rd_err == 0, "R2", "readback sweep mismatches", rd_err, 0);
    end_phase("R9", "no ticks without reference");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule